// File: doc/BRIEF.md
# Display Frame Descriptor Fetch Engine

This block loads new frame descriptors for a bank of display DMA channels. When it sees a frame-start strobe it first clears every channel's source address. It then takes the channels one at a time in ascending order. For each enabled channel it reads a four-word descriptor from memory through a single-word request/valid port. The four words are the next-descriptor pointer, the frame source address, the frame identifier and the command word. They are written into that channel's register set. The fetched pointer replaces the stored one, so the descriptors in memory form a linked list that advances by one entry per frame.

Software can redirect a channel for one frame through its branch register. A pending branch request takes the place of the linked pointer, is cleared once it has been used, and can raise a branch event. Before any memory access the engine checks that the 16-byte descriptor lies wholly inside a configured memory window. A channel that fails the check is skipped and keeps a zero source address. Every enabled channel that finishes with a zero source address raises a bus-error event carrying its channel number. Each successful load raises a load event that carries the palette flag and byte length decoded from the command word. Pixel fetch, palette handling and interrupt merging belong to other blocks.

Top module: `fdesc_fetch_engine`

## Requirements
- R1: After reset every channel register reads zero, `busy` and `frame_done` are low and `mem_req` is low. `mem_req` is never high while `busy` is low.
- R2: A host write to offset 0x200+16*ch stores the value in that channel's next-descriptor pointer with bits 3:0 forced to zero. Host writes to offsets +0x4 (source), +0x8 (frame ID) and +0xC (command) have no effect. Reads at +0x0/+0x4/+0x8/+0xC return pointer, source, ID and command.
- R3: A host write to the branch register at offset 0x180+4*ch keeps only the bits in mask 0xFFFFFFF3. Bit 0 is the branch request, bit 1 the branch-event enable and bits 31:4 the branch descriptor address.
- R4: A frame-start strobe while idle zeroes the source address of every channel. Enabled channels (`ch_enable[ch]`=1) are then processed in ascending channel order. Disabled channels make no memory request and read a zero source.
- R5: For a channel whose pointer is P, the engine reads the words at P, P+4, P+8 and P+12. These words become that channel's next pointer, source, frame ID and command in that order.
- R6: When branch bit 0 is set, the fetch uses address {bits 31:4, 4'h0} of the branch register instead of the stored pointer, and bit 0 is then cleared. A one-cycle `branch_evt` with `evt_ch`=ch occurs only if bit 1 is also set.
- R7: A descriptor is fetched only if WIN_BASE <= P and P+16 <= WIN_BASE+WIN_SIZE. Otherwise no memory request is made for that channel and its source stays zero. Every `mem_addr` issued lies inside the window.
- R8: An enabled channel whose source is zero after its step (window reject or a fetched zero source) produces a one-cycle `buserr_evt` with `evt_ch`=ch, and no `load_evt`.
- R9: A fetch with a nonzero source produces a one-cycle `load_evt` with `evt_ch`=ch. It also gives `load_pal` = command bit 26 and `load_len` = command bits 20:2 as a byte count (command & 0x1FFFFC).
- R10: `busy` rises the cycle after an accepted frame-start. `frame_done` pulses for one cycle after the last channel and is followed by `busy` low. A frame-start seen while `busy` is high is ignored.
- R11: `mem_req` stays high with a stable `mem_addr` until a cycle with `mem_rvalid` high. That cycle transfers exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame-start strobe |
| ch_enable | input | NUM_CH | Per-channel enable |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | HOST_AW | Host write offset |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | HOST_AW | Host read offset |
| host_rdata | output | 32 | Host read data (combinational) |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Frame walk in progress |
| frame_done | output | 1 | One-cycle pulse at the end of a walk |
| branch_evt | output | 1 | Branch event pulse |
| buserr_evt | output | 1 | Bus-error event pulse |
| load_evt | output | 1 | Descriptor loaded pulse |
| evt_ch | output | CH_W | Channel of the current event |
| load_pal | output | 1 | Palette flag of the loaded command |
| load_len | output | 21 | Byte length of the loaded command |

## Verification
The bound checker watches the memory port handshake on every cycle: the request is held until valid, every address stays inside the window, and there is no request while idle. It also checks that `frame_done` is followed by idle, that `busy` only rises after a strobe, and that event channel numbers and lengths are well formed. Only the directed scenarios can show the data path. That covers the linked-list advance across frames, the word order into the registers, the one-shot branch redirect and its clearing, exact-fit and out-of-window boundaries, channel ordering, and the suppression of a strobe that arrives mid-walk.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int WORD_W      = 32;
  localparam int DESC_WORDS  = 4;
  localparam int CH_REG_BASE = 'h200;
  localparam int CH_REG_STEP = 16;
  localparam int BR_REG_BASE = 'h180;
  localparam int BR_REG_STEP = 4;
  localparam logic [WORD_W-1:0] BR_KEEP_MASK = 32'hFFFF_FFF3;
  localparam logic [WORD_W-1:0] LEN_MASK     = 32'h001F_FFFC;
  localparam int CMD_PAL_BIT = 26;
  localparam int BR_REQ_BIT  = 0;
  localparam int BR_INT_BIT  = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FETCH,
    ST_COMMIT,
    ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] fid;
    logic [WORD_W-1:0] cmd;
  } desc_t;
endpackage

// File: rtl/fdf_host_decode.sv
module fdf_host_decode
  import fdf_pkg::*;
#(
  parameter int NUM_CH  = 7,
  parameter int HOST_AW = 12
) (
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_waddr,
  input  logic [HOST_AW-1:0] host_raddr,
  input  logic [WORD_W-1:0]  next_i [NUM_CH],
  input  logic [WORD_W-1:0]  src_i  [NUM_CH],
  input  logic [WORD_W-1:0]  fid_i  [NUM_CH],
  input  logic [WORD_W-1:0]  cmd_i  [NUM_CH],
  input  logic [WORD_W-1:0]  br_i   [NUM_CH],
  output logic [NUM_CH-1:0]  wr_next_en,
  output logic [NUM_CH-1:0]  wr_br_en,
  output logic [WORD_W-1:0]  rdata
);
  // write strobes, one per channel register
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_wdec
    localparam logic [HOST_AW-1:0] NXT_OFF = HOST_AW'(CH_REG_BASE + CH_REG_STEP*ch);
    localparam logic [HOST_AW-1:0] BR_OFF  = HOST_AW'(BR_REG_BASE + BR_REG_STEP*ch);
    assign wr_next_en[ch] = host_wr && (host_waddr == NXT_OFF);
    assign wr_br_en[ch]   = host_wr && (host_waddr == BR_OFF);
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (host_raddr == HOST_AW'(CH_REG_BASE + CH_REG_STEP*ch))      rdata = next_i[ch];
      if (host_raddr == HOST_AW'(CH_REG_BASE + CH_REG_STEP*ch + 4))  rdata = src_i[ch];
      if (host_raddr == HOST_AW'(CH_REG_BASE + CH_REG_STEP*ch + 8))  rdata = fid_i[ch];
      if (host_raddr == HOST_AW'(CH_REG_BASE + CH_REG_STEP*ch + 12)) rdata = cmd_i[ch];
      if (host_raddr == HOST_AW'(BR_REG_BASE + BR_REG_STEP*ch))      rdata = br_i[ch];
    end
  end
endmodule

// File: rtl/fdf_chan_regs.sv
module fdf_chan_regs
  import fdf_pkg::*;
#(
  parameter int NUM_CH = 7,
  localparam int CH_W  = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] wr_next_en,
  input  logic [NUM_CH-1:0] wr_br_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clr_src,
  input  logic              commit,
  input  logic [CH_W-1:0]   commit_ch,
  input  desc_t             commit_desc,
  input  logic              br_clr,
  input  logic [CH_W-1:0]   br_clr_ch,
  output logic [WORD_W-1:0] next_o [NUM_CH],
  output logic [WORD_W-1:0] src_o  [NUM_CH],
  output logic [WORD_W-1:0] fid_o  [NUM_CH],
  output logic [WORD_W-1:0] cmd_o  [NUM_CH],
  output logic [WORD_W-1:0] br_o   [NUM_CH]
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [WORD_W-1:0] next_q, src_q, fid_q, cmd_q, br_q;
    logic [WORD_W-1:0] next_d, src_d, fid_d, cmd_d, br_d;
    logic              hit_commit, hit_brclr, en_reg;

    assign hit_commit = commit && (commit_ch == CH_W'(ch));
    assign hit_brclr  = br_clr && (br_clr_ch == CH_W'(ch));

    always_comb begin
      next_d = next_q;
      src_d  = src_q;
      fid_d  = fid_q;
      cmd_d  = cmd_q;
      br_d   = br_q;
      // a fetched pointer has priority over a host write in the same cycle
      if (hit_commit)          next_d = commit_desc.nxt;
      else if (wr_next_en[ch]) next_d = {wdata[WORD_W-1:4], 4'h0};
      if (clr_src)             src_d  = '0;
      else if (hit_commit)     src_d  = commit_desc.src;
      if (hit_commit) begin
        fid_d = commit_desc.fid;
        cmd_d = commit_desc.cmd;
      end
      // a host write has priority over the one-shot clear
      if (wr_br_en[ch])        br_d = wdata & BR_KEEP_MASK;
      else if (hit_brclr)      br_d[BR_REQ_BIT] = 1'b0;
    end

    assign en_reg = hit_commit || wr_next_en[ch] || clr_src || wr_br_en[ch] || hit_brclr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        next_q <= '0;
        src_q  <= '0;
        fid_q  <= '0;
        cmd_q  <= '0;
        br_q   <= '0;
      end else if (en_reg) begin
        next_q <= next_d;
        src_q  <= src_d;
        fid_q  <= fid_d;
        cmd_q  <= cmd_d;
        br_q   <= br_d;
      end
    end

    assign next_o[ch] = next_q;
    assign src_o[ch]  = src_q;
    assign fid_o[ch]  = fid_q;
    assign cmd_o[ch]  = cmd_q;
    assign br_o[ch]   = br_q;
  end
endmodule

// File: rtl/fdf_win_check.sv
module fdf_win_check
  import fdf_pkg::*;
#(
  parameter logic [WORD_W-1:0] WIN_BASE = 32'hA000_0000,
  parameter logic [WORD_W-1:0] WIN_SIZE = 32'h0001_0000
) (
  input  logic [WORD_W-1:0] ptr,
  output logic              fits
);
  localparam logic [WORD_W:0] LO_EDGE = {1'b0, WIN_BASE};
  localparam logic [WORD_W:0] HI_EDGE = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};
  localparam logic [WORD_W:0] SPAN    = (WORD_W+1)'(DESC_WORDS * 4);

  logic [WORD_W:0] ptr_ext, ptr_end;
  assign ptr_ext = {1'b0, ptr};
  assign ptr_end = ptr_ext + SPAN;
  assign fits    = (ptr_ext >= LO_EDGE) && (ptr_end <= HI_EDGE);
endmodule

// File: rtl/fdf_walker.sv
module fdf_walker
  import fdf_pkg::*;
#(
  parameter int NUM_CH = 7,
  localparam int CH_W  = $clog2(NUM_CH + 1),
  localparam int CH_IW = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [WORD_W-1:0] next_i [NUM_CH],
  input  logic [WORD_W-1:0] br_i   [NUM_CH],
  input  logic              win_ok,
  output logic [WORD_W-1:0] cand_ptr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  output logic              clr_src,
  output logic              commit,
  output logic [CH_W-1:0]   commit_ch,
  output desc_t             commit_desc,
  output logic              br_clr,
  output logic              busy,
  output logic              frame_done,
  output logic              branch_evt,
  output logic              buserr_evt,
  output logic              load_evt,
  output logic [CH_W-1:0]   evt_ch,
  output logic              load_pal,
  output logic [20:0]       load_len
);
  walk_state_e       state_q, state_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [1:0]        word_q, word_d;
  logic [WORD_W-1:0] ptr_q, ptr_d;
  logic [WORD_W-1:0] buf_q [DESC_WORDS];
  logic [WORD_W-1:0] buf_d [DESC_WORDS];
  logic              br_evt_d, be_evt_d, ld_evt_d;
  logic              br_evt_q, be_evt_q, ld_evt_q;
  logic [CH_W-1:0]   evt_ch_q;
  logic              pal_q;
  logic [20:0]       len_q;
  logic [CH_IW-1:0]  ch_sel;
  logic [WORD_W-1:0] cur_br;
  logic              cur_en, in_range, any_evt;

  assign in_range = (ch_q < CH_W'(NUM_CH));
  assign ch_sel   = in_range ? ch_q[CH_IW-1:0] : '0;
  assign cur_br   = br_i[ch_sel];
  assign cur_en   = in_range && ch_enable[ch_sel];
  assign cand_ptr = cur_br[BR_REQ_BIT] ? {cur_br[WORD_W-1:4], 4'h0} : next_i[ch_sel];

  assign commit_desc = '{nxt: buf_q[0], src: buf_q[1], fid: buf_q[2], cmd: buf_q[3]};
  assign commit_ch   = ch_q;

  always_comb begin
    state_d  = state_q;
    ch_d     = ch_q;
    word_d   = word_q;
    ptr_d    = ptr_q;
    buf_d    = buf_q;
    br_evt_d = 1'b0;
    be_evt_d = 1'b0;
    ld_evt_d = 1'b0;
    clr_src  = 1'b0;
    commit   = 1'b0;
    br_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_start) begin
          clr_src = 1'b1;
          ch_d    = '0;
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (!in_range) begin
          state_d = ST_DONE;
        end else if (!cur_en) begin
          ch_d = ch_q + 1'b1;
        end else begin
          if (cur_br[BR_REQ_BIT]) begin
            br_clr   = 1'b1;
            br_evt_d = cur_br[BR_INT_BIT];
          end
          if (win_ok) begin
            ptr_d   = cand_ptr;
            word_d  = '0;
            state_d = ST_FETCH;
          end else begin
            be_evt_d = 1'b1;
            ch_d     = ch_q + 1'b1;
          end
        end
      end
      ST_FETCH: begin
        if (mem_rvalid) begin
          buf_d[word_q] = mem_rdata;
          if (word_q == 2'(DESC_WORDS - 1)) state_d = ST_COMMIT;
          else                              word_d  = word_q + 1'b1;
        end
      end
      ST_COMMIT: begin
        commit = 1'b1;
        if (buf_q[1] == '0) be_evt_d = 1'b1;
        else                ld_evt_d = 1'b1;
        ch_d    = ch_q + 1'b1;
        state_d = ST_SCAN;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign any_evt = br_evt_d || be_evt_d || ld_evt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      word_q  <= '0;
      ptr_q   <= '0;
      for (int i = 0; i < DESC_WORDS; i++) buf_q[i] <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      word_q  <= word_d;
      ptr_q   <= ptr_d;
      if (state_q == ST_FETCH && mem_rvalid) buf_q <= buf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_evt_q <= 1'b0;
      be_evt_q <= 1'b0;
      ld_evt_q <= 1'b0;
      evt_ch_q <= '0;
      pal_q    <= 1'b0;
      len_q    <= '0;
    end else begin
      br_evt_q <= br_evt_d;
      be_evt_q <= be_evt_d;
      ld_evt_q <= ld_evt_d;
      if (any_evt) evt_ch_q <= ch_q;
      if (ld_evt_d) begin
        pal_q <= buf_q[3][CMD_PAL_BIT];
        len_q <= buf_q[3][20:0] & LEN_MASK[20:0];
      end
    end
  end

  assign mem_req    = (state_q == ST_FETCH);
  assign mem_addr   = ptr_q + {{(WORD_W-4){1'b0}}, word_q, 2'b00};
  assign busy       = (state_q != ST_IDLE);
  assign frame_done = (state_q == ST_DONE);
  assign branch_evt = br_evt_q;
  assign buserr_evt = be_evt_q;
  assign load_evt   = ld_evt_q;
  assign evt_ch     = evt_ch_q;
  assign load_pal   = pal_q;
  assign load_len   = len_q;
endmodule

// File: rtl/fdesc_fetch_engine.sv
module fdesc_fetch_engine
  import fdf_pkg::*;
#(
  parameter int NUM_CH  = 7,
  parameter int HOST_AW = 12,
  parameter logic [31:0] WIN_BASE = 32'hA000_0000,
  parameter logic [31:0] WIN_SIZE = 32'h0001_0000,
  localparam int CH_W = $clog2(NUM_CH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [NUM_CH-1:0]  ch_enable,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_waddr,
  input  logic [31:0]        host_wdata,
  input  logic [HOST_AW-1:0] host_raddr,
  output logic [31:0]        host_rdata,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  output logic               busy,
  output logic               frame_done,
  output logic               branch_evt,
  output logic               buserr_evt,
  output logic               load_evt,
  output logic [CH_W-1:0]    evt_ch,
  output logic               load_pal,
  output logic [20:0]        load_len
);
  logic [WORD_W-1:0] next_w [NUM_CH];
  logic [WORD_W-1:0] src_w  [NUM_CH];
  logic [WORD_W-1:0] fid_w  [NUM_CH];
  logic [WORD_W-1:0] cmd_w  [NUM_CH];
  logic [WORD_W-1:0] br_w   [NUM_CH];
  logic [NUM_CH-1:0] wr_next_en, wr_br_en;
  logic              clr_src, commit, br_clr, win_ok;
  logic [CH_W-1:0]   commit_ch;
  desc_t             commit_desc;
  logic [WORD_W-1:0] cand_ptr;

  fdf_host_decode #(.NUM_CH(NUM_CH), .HOST_AW(HOST_AW)) u_dec (
    .host_wr    (host_wr),
    .host_waddr (host_waddr),
    .host_raddr (host_raddr),
    .next_i     (next_w),
    .src_i      (src_w),
    .fid_i      (fid_w),
    .cmd_i      (cmd_w),
    .br_i       (br_w),
    .wr_next_en (wr_next_en),
    .wr_br_en   (wr_br_en),
    .rdata      (host_rdata)
  );

  fdf_chan_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_next_en  (wr_next_en),
    .wr_br_en    (wr_br_en),
    .wdata       (host_wdata),
    .clr_src     (clr_src),
    .commit      (commit),
    .commit_ch   (commit_ch),
    .commit_desc (commit_desc),
    .br_clr      (br_clr),
    .br_clr_ch   (commit_ch),
    .next_o      (next_w),
    .src_o       (src_w),
    .fid_o       (fid_w),
    .cmd_o       (cmd_w),
    .br_o        (br_w)
  );

  fdf_win_check #(.WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_win (
    .ptr  (cand_ptr),
    .fits (win_ok)
  );

  fdf_walker #(.NUM_CH(NUM_CH)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .ch_enable   (ch_enable),
    .next_i      (next_w),
    .br_i        (br_w),
    .win_ok      (win_ok),
    .cand_ptr    (cand_ptr),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .clr_src     (clr_src),
    .commit      (commit),
    .commit_ch   (commit_ch),
    .commit_desc (commit_desc),
    .br_clr      (br_clr),
    .busy        (busy),
    .frame_done  (frame_done),
    .branch_evt  (branch_evt),
    .buserr_evt  (buserr_evt),
    .load_evt    (load_evt),
    .evt_ch      (evt_ch),
    .load_pal    (load_pal),
    .load_len    (load_len)
  );
endmodule

// File: rtl/fdf_checker.sv
module fdf_checker #(
  parameter int NUM_CH = 7,
  parameter logic [31:0] WIN_BASE = 32'hA000_0000,
  parameter logic [31:0] WIN_SIZE = 32'h0001_0000,
  localparam int CH_W = $clog2(NUM_CH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_start,
  input logic            mem_req,
  input logic [31:0]     mem_addr,
  input logic            mem_rvalid,
  input logic            busy,
  input logic            frame_done,
  input logic            branch_evt,
  input logic            buserr_evt,
  input logic            load_evt,
  input logic [CH_W-1:0] evt_ch,
  input logic [20:0]     load_len
);
  localparam logic [32:0] HI_EDGE = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R7
  win_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr >= WIN_BASE) && (({1'b0, mem_addr} + 33'd4) <= HI_EDGE)));

  // R1
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_start));

  // R8
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_evt && buserr_evt));

  // R8
  evt_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt || buserr_evt || branch_evt) |-> (evt_ch < CH_W'(NUM_CH)));

  // R9
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (load_len[1:0] == 2'b00));
endmodule

bind fdesc_fetch_engine fdf_checker #(
  .NUM_CH(NUM_CH), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .busy(busy),
  .frame_done(frame_done), .branch_evt(branch_evt), .buserr_evt(buserr_evt),
  .load_evt(load_evt), .evt_ch(evt_ch), .load_len(load_len)
);

// File: tb/fdesc_fetch_engine_test.sv
module fdesc_fetch_engine_test;
  localparam int NCH = 7;
  localparam logic [31:0] BASE = 32'hA000_0000;
  localparam logic [31:0] SIZE = 32'h0001_0000;
  localparam logic [31:0] FAR_K = 32'h5555_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [NCH-1:0] ch_enable = '0;
  logic host_wr = 1'b0;
  logic [11:0] host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [11:0] host_raddr = '0;
  logic [31:0] host_rdata;
  logic mem_req;
  logic [31:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic busy, frame_done, branch_evt, buserr_evt, load_evt, load_pal;
  logic [2:0] evt_ch;
  logic [20:0] load_len;

  always #2.5 clk = ~clk;

  fdesc_fetch_engine uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_enable(ch_enable),
    .host_wr(host_wr), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .frame_done(frame_done), .branch_evt(branch_evt), .buserr_evt(buserr_evt),
    .load_evt(load_evt), .evt_ch(evt_ch), .load_pal(load_pal), .load_len(load_len)
  );

  int checks = 0;
  int fails = 0;

  // memory model: first 1 KB from an array, beyond that address ^ FAR_K
  logic [31:0] mem [0:255];
  int mem_lat = 0;
  int wait_cnt = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] off;
    off = a - BASE;
    if (off < 32'd1024) return mem[off[9:2]];
    return a ^ FAR_K;
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_rvalid) begin
      if (wait_cnt >= mem_lat) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_word(mem_addr);
        wait_cnt   <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  // event / access logs
  logic [31:0] acc_addr [0:63];
  int acc_n = 0;
  logic [2:0] ld_ch [0:15];
  logic ld_pal [0:15];
  logic [20:0] ld_len [0:15];
  int ld_n = 0;
  logic [7:0] berr_mask = '0;
  int br_n = 0;
  logic [2:0] br_ch = '0;
  int done_n = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_rvalid && acc_n < 64) begin
        acc_addr[acc_n] <= mem_addr;
        acc_n <= acc_n + 1;
      end
      if (load_evt && ld_n < 16) begin
        ld_ch[ld_n] <= evt_ch; ld_pal[ld_n] <= load_pal; ld_len[ld_n] <= load_len;
        ld_n <= ld_n + 1;
      end
      if (buserr_evt) berr_mask[evt_ch] <= 1'b1;
      if (branch_evt) begin br_n <= br_n + 1; br_ch <= evt_ch; end
      if (frame_done) done_n <= done_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_raddr = a;
    #1;
    d = host_rdata;
  endtask

  function automatic logic [11:0] chreg(input int ch, input int off);
    return 12'(32'h200 + 16*ch + off);
  endfunction

  task automatic clear_logs();
    @(negedge clk);
    acc_n = 0; ld_n = 0; berr_mask = '0; br_n = 0; done_n = 0;
  endtask

  task automatic run_frame();
    int guard;
    clear_logs();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    guard = 0;
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  task automatic put_desc(input int widx, input logic [31:0] n, input logic [31:0] s,
                          input logic [31:0] f, input logic [31:0] c);
    mem[widx] = n; mem[widx+1] = s; mem[widx+2] = f; mem[widx+3] = c;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] v;
    logic bad;
    bad = 1'b0;
    for (int ch = 0; ch < NCH; ch++) begin
      for (int o = 0; o < 16; o += 4) begin
        hread(chreg(ch, o), v);
        if (v != 0) bad = 1'b1;
      end
      hread(12'(32'h180 + 4*ch), v);
      if (v != 0) bad = 1'b1;
    end
    chk(!bad, "R1 regs zero", {31'd0, bad}, 32'd0);
    chk(!busy && !frame_done && !mem_req, "R1 idle outputs", {29'd0, busy, frame_done, mem_req}, 32'd0);
  endtask

  task automatic t_host_regs();
    logic [31:0] v;
    hwrite(chreg(2, 0), 32'hA000_0123);
    hread(chreg(2, 0), v);
    chk(v == 32'hA000_0120, "R2 next ptr low bits", v, 32'hA000_0120);
    hwrite(chreg(1, 4), 32'h0000_FFFF);
    hwrite(chreg(1, 8), 32'h1234_5678);
    hwrite(chreg(1, 12), 32'h0400_0100);
    hread(chreg(1, 4), v);
    chk(v == 0, "R2 source read-only", v, 0);
    hread(chreg(1, 12), v);
    chk(v == 0, "R2 command read-only", v, 0);
    hwrite(12'h18C, 32'hFFFF_FFFF);
    hread(12'h18C, v);
    chk(v == 32'hFFFF_FFF3, "R3 branch mask", v, 32'hFFFF_FFF3);
    hwrite(12'h18C, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    bit ok;
    put_desc(0,  BASE + 32'h40, BASE + 32'h300, 32'h11, 32'h0400_0103);
    put_desc(8,  BASE + 32'h60, 32'h1234_5678,  32'h22, 32'h0000_0040);
    put_desc(16, BASE + 32'h00, BASE + 32'h380, 32'h33, 32'h0000_0200);
    hwrite(chreg(0, 0), BASE + 32'h00);
    hwrite(chreg(2, 0), BASE + 32'h20);
    ch_enable = 7'b000_0101;
    run_frame();
    ok = (acc_n == 8);
    for (int i = 0; i < 4; i++) begin
      if (acc_addr[i]   != BASE + 32'(4*i))        ok = 1'b0;
      if (acc_addr[4+i] != BASE + 32'h20 + 32'(4*i)) ok = 1'b0;
    end
    chk(ok, "R5 fetch addresses", 32'(acc_n), 32'd8);
    hread(chreg(0, 0), v); chk(v == BASE + 32'h40, "R5 ch0 next", v, BASE + 32'h40);
    hread(chreg(0, 4), v); chk(v == BASE + 32'h300, "R5 ch0 source", v, BASE + 32'h300);
    hread(chreg(0, 8), v); chk(v == 32'h11, "R5 ch0 id", v, 32'h11);
    hread(chreg(2, 12), v); chk(v == 32'h40, "R5 ch2 command", v, 32'h40);
    chk(ld_n == 2 && ld_ch[0] == 3'd0 && ld_ch[1] == 3'd2, "R4 channel order",
        {ld_ch[0], ld_ch[1]}, {3'd0, 3'd2});
    chk(ld_pal[0] == 1'b1 && ld_len[0] == 21'h100, "R9 ch0 palette/length",
        {ld_pal[0], ld_len[0]}, {1'b1, 21'h100});
    chk(ld_pal[1] == 1'b0 && ld_len[1] == 21'h40, "R9 ch2 palette/length",
        {ld_pal[1], ld_len[1]}, {1'b0, 21'h40});
    hread(chreg(1, 4), v); chk(v == 0 && berr_mask == 0, "R4 disabled ch1 untouched", v, 0);
    chk(done_n == 1, "R10 one done pulse", 32'(done_n), 1);
  endtask

  task automatic t_linked();
    logic [31:0] v;
    run_frame();
    hread(chreg(0, 4), v);
    chk(v == 32'h1234_5678 || v == BASE + 32'h380, "R5 linked list advance", v, BASE + 32'h380);
    chk(acc_addr[0] == BASE + 32'h40, "R5 ch0 followed link", acc_addr[0], BASE + 32'h40);
    // disable ch0: its source must be reset to zero by the frame start
    ch_enable = 7'b000_0100;
    run_frame();
    hread(chreg(0, 4), v);
    chk(v == 0, "R4 disabled channel source cleared", v, 0);
  endtask

  task automatic t_branch();
    logic [31:0] v;
    put_desc(32, BASE + 32'h00, BASE + 32'h3C0, 32'h44, 32'h0);
    put_desc(40, BASE + 32'h00, BASE + 32'h3D0, 32'h55, 32'h0);
    ch_enable = 7'b000_0101;
    hwrite(12'h180, BASE + 32'h80 + 32'h3);
    hwrite(12'h188, BASE + 32'hA0 + 32'h1);
    run_frame();
    chk(acc_addr[0] == BASE + 32'h80, "R6 branch redirect ch0", acc_addr[0], BASE + 32'h80);
    chk(acc_addr[4] == BASE + 32'hA0, "R6 branch redirect ch2", acc_addr[4], BASE + 32'hA0);
    chk(br_n == 1 && br_ch == 3'd0, "R6 branch event only with bit1", 32'(br_n), 1);
    hread(12'h180, v);
    chk(v == BASE + 32'h82, "R6 request bit cleared", v, BASE + 32'h82);
    hread(chreg(2, 8), v);
    chk(v == 32'h55, "R6 branch descriptor loaded", v, 32'h55);
    run_frame();
    chk(acc_addr[0] == BASE + 32'h00 && br_n == 0, "R6 branch is one-shot", acc_addr[0], BASE);
  endtask

  task automatic t_window();
    logic [31:0] v;
    logic [31:0] edge_ptr;
    edge_ptr = BASE + SIZE - 32'd16;
    ch_enable = 7'b111_0000;
    hwrite(chreg(4, 0), edge_ptr);
    hwrite(chreg(5, 0), BASE + SIZE);
    hwrite(chreg(6, 0), 32'h0);
    run_frame();
    chk(acc_n == 4 && acc_addr[0] == edge_ptr, "R7 only exact fit fetched", 32'(acc_n), 4);
    hread(chreg(4, 4), v);
    chk(v == ((edge_ptr + 4) ^ FAR_K), "R7 exact-fit source", v, (edge_ptr + 4) ^ FAR_K);
    hread(chreg(5, 4), v);
    chk(v == 0, "R7 past-end source zero", v, 0);
    chk(berr_mask == 8'b0110_0000, "R8 bus error for ch5 and ch6", {24'd0, berr_mask}, 32'h60);
  endtask

  task automatic t_zero_src();
    logic [31:0] v;
    put_desc(48, BASE + 32'h10, 32'h0, 32'h66, 32'h0400_0000);
    ch_enable = 7'b000_1000;
    hwrite(chreg(3, 0), BASE + 32'hC0);
    run_frame();
    chk(berr_mask == 8'b0000_1000 && ld_n == 0, "R8 zero fetched source", {24'd0, berr_mask}, 32'h08);
    hread(chreg(3, 0), v);
    chk(v == BASE + 32'h10, "R8 pointer still advances", v, BASE + 32'h10);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    mem_lat = 3;
    ch_enable = 7'b000_0100;
    hwrite(chreg(2, 0), BASE + 32'h20);
    run_frame();
    chk(acc_n == 4, "R11 one word per handshake", 32'(acc_n), 4);
    hread(chreg(2, 8), v);
    chk(v == 32'h22, "R11 slow memory data", v, 32'h22);
    mem_lat = 0;
  endtask

  task automatic t_busy();
    int guard;
    ch_enable = 7'b000_0101;
    hwrite(chreg(0, 0), BASE);
    hwrite(chreg(2, 0), BASE + 32'h20);
    clear_logs();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    chk(busy, "R10 busy after start", {31'd0, busy}, 1);
    repeat (3) @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    guard = 0;
    while (guard < 200) begin @(negedge clk); guard++; end
    chk(done_n == 1 && !busy, "R10 start while busy ignored", 32'(done_n), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host_regs();
    t_chain();
    t_linked();
    t_branch();
    t_window();
    t_zero_src();
    t_latency();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule